// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to sixteen interrupt sources for a small processor core. Every source owns a pending flag and an enable bit. A hardware event pulse sets a flag, and software can also set or clear flags by writing the flag word. A source makes a request when its flag and its enable bit are both set and the global enable input is high. Sources in the non-maskable group skip the global enable. When several sources request at once, the controller reports the one with the highest index, together with a fixed 16-bit vector address for that entry.

The CPU pulses `accept` when it takes the interrupt. On that edge the controller clears the flag of the selected source, but only if that source is configured as single-source. Flags of multi-source entries, such as a shared non-maskable group, stay set until software clears them. A small register port gives software read and write access to the flag word and the enable word. The CPU itself, stacking and the vector memory contents are outside this block.

Top module: `irqc_top`

## Requirements
- R1: On reset the flag word and the enable word are both 0 and `irq_req` is low.
- R2: A maskable source requests only when its flag, its enable bit and `gie` are all 1.
- R3: A write with `reg_sel`=0 loads the flag word, and a flag set this way requests exactly like one set by `hw_event`.
- R4: When several sources request, `irq_idx` is the highest requesting index. Index 15 beats index 14.
- R5: `irq_vector` equals 0xFFE0 + 2*`irq_idx`, so entry 15 maps to 0xFFFE. With no request it reads 0xFFE0.
- R6: An `accept` while `irq_req` is high clears the selected flag when that source is single-source. The default single-source mask is 0xBFF7.
- R7: An `accept` leaves the selected flag set when the source is multi-source (default: indices 3 and 14).
- R8: A `hw_event` bit in the same cycle as a software write that clears that flag leaves the flag set.
- R9: An `accept` while `irq_req` is low changes no flag.
- R10: Non-maskable sources (default mask 0xC000, indices 14 and 15) request with `gie` low if flag and enable are set.
- R11: `reg_rdata` shows the flag word when `reg_sel`=0 and the enable word when `reg_sel`=1. A write with `reg_sel`=1 loads the enable word.
- R12: A `hw_event` bit in the same cycle as an `accept` that would clear that single-source flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_event | input | 16 | One pulse per source, sets its flag |
| gie | input | 1 | Global enable for maskable sources |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag word, 1 selects the enable word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| accept | input | 1 | CPU takes the current request |
| irq_req | output | 1 | A source is requesting |
| irq_idx | output | 4 | Index of the winning source |
| irq_vector | output | 16 | Vector address of the winning source |

## Verification
A flag has three writers that can act in the same cycle: the hardware event, the software write, and the hardware clear on acceptance. The bench drives a hardware event on the same edge as a software write of zero to that flag, and again on the same edge as an acceptance of a single-source flag. It then reads the flag word back through the register port on the next sample and expects the bit to still be set, with the request and vector still pointing at that source. It also accepts a multi-source entry and accepts while gated, and checks that no flag moves in either case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } regsel_e;

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
    import irqc_pkg::*;
#(
    parameter int unsigned           NUM_SRC     = 16,
    parameter logic [NUM_SRC-1:0]    SINGLE_MASK = 16'hBFF7,
    localparam int unsigned          IDX_W       = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   hw_event,
    input  logic                 reg_we,
    input  logic                 reg_sel,
    input  logic [NUM_SRC-1:0]   reg_wdata,
    input  logic                 acc_fire,
    input  logic [IDX_W-1:0]     acc_idx,
    output logic [NUM_SRC-1:0]   flag_q,
    output logic [NUM_SRC-1:0]   en_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_SRC-1:0] en;
    } bank_t;

    bank_t              st_d, st_q;
    logic [NUM_SRC-1:0] acc_clr_d;
    regsel_e            sel_d;

    always_comb begin
        st_d      = st_q;
        sel_d     = regsel_e'(reg_sel);
        acc_clr_d = '0;
        if (acc_fire && SINGLE_MASK[acc_idx]) begin
            acc_clr_d[acc_idx] = 1'b1;
        end
        if (reg_we && sel_d == SEL_FLAGS) begin
            st_d.flag = reg_wdata;
        end else begin
            st_d.flag = st_q.flag & ~acc_clr_d;
        end
        if (reg_we && sel_d == SEL_ENABLES) begin
            st_d.en = reg_wdata;
        end
        st_d.flag = st_d.flag | hw_event;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;

    AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && |hw_event) |=> ((flag_q & $past(hw_event)) == $past(hw_event))); // R8

    AST_EVENT_BEATS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && |hw_event) |=> ((flag_q & $past(hw_event)) == $past(hw_event))); // R12

    AST_SINGLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !reg_we && SINGLE_MASK[acc_idx] && !hw_event[acc_idx])
        |=> !flag_q[$past(acc_idx)]); // R6

    AST_MULTI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !reg_we && !SINGLE_MASK[acc_idx] && flag_q[acc_idx])
        |=> flag_q[$past(acc_idx)]); // R7

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int unsigned  NUM_SRC = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_vector_gen.sv
module irqc_vector_gen #(
    parameter int unsigned  NUM_SRC = 16,
    parameter int unsigned  ADDR_W  = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] vector
);

    localparam int unsigned        BASE_INT = (1 << ADDR_W) - 2 * NUM_SRC;
    localparam logic [ADDR_W-1:0]  BASE_V   = ADDR_W'(BASE_INT);

    always_comb begin
        vector = BASE_V + ADDR_W'({idx, 1'b0});
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned          NUM_SRC      = 16,
    parameter int unsigned          ADDR_W       = 16,
    parameter logic [NUM_SRC-1:0]   SINGLE_MASK  = 16'hBFF7,
    parameter logic [NUM_SRC-1:0]   NONMASK_MASK = 16'hC000,
    localparam int unsigned         IDX_W        = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   hw_event,
    input  logic                 gie,
    input  logic                 reg_we,
    input  logic                 reg_sel,
    input  logic [NUM_SRC-1:0]   reg_wdata,
    output logic [NUM_SRC-1:0]   reg_rdata,
    input  logic                 accept,
    output logic                 irq_req,
    output logic [IDX_W-1:0]     irq_idx,
    output logic [ADDR_W-1:0]    irq_vector
);

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend;
    logic               acc_fire;

    irqc_flag_bank #(
        .NUM_SRC     (NUM_SRC),
        .SINGLE_MASK (SINGLE_MASK)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_event  (hw_event),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .acc_fire  (acc_fire),
        .acc_idx   (irq_idx),
        .flag_q    (flag_q),
        .en_q      (en_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        if (NONMASK_MASK[g]) begin : g_nmi
            assign pend[g] = flag_q[g] & en_q[g];
        end else begin : g_mask
            assign pend[g] = flag_q[g] & en_q[g] & gie;
        end
    end

    irqc_prio_enc #(
        .NUM_SRC (NUM_SRC)
    ) u_enc (
        .pend (pend),
        .any  (irq_req),
        .idx  (irq_idx)
    );

    irqc_vector_gen #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_vec (
        .idx    (irq_idx),
        .vector (irq_vector)
    );

    assign acc_fire  = accept & irq_req;
    assign reg_rdata = (regsel_e'(reg_sel) == SEL_ENABLES) ? en_q : flag_q;

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag_q[irq_idx] && en_q[irq_idx])); // R2

    AST_MASKED_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !NONMASK_MASK[irq_idx]) |-> gie); // R10

    AST_NONE_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (((pend >> irq_idx) >> 1) == '0)); // R4

    AST_IDLE_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !irq_req && !reg_we && !(|hw_event)) |=> $stable(flag_q)); // R9

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_event = '0;
    logic        gie = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        accept = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_idx;
    logic [15:0] irq_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqc_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_event   (hw_event),
        .gie        (gie),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .accept     (accept),
        .irq_req    (irq_req),
        .irq_idx    (irq_idx),
        .irq_vector (irq_vector)
    );

    typedef struct packed {
        logic        we;
        logic        sel;
        logic [15:0] wdata;
        logic [15:0] hw;
        logic        g;
        logic        acc;
        logic        ereq;
        logic [15:0] evec;
        logic [15:0] erd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 1'b1, 16'h0FFF, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hFFE0, 16'h0FFF, 4'd11}, // R11 enables
        '{1'b0, 1'b0, 16'h0000, 16'h0012, 1'b1, 1'b0, 1'b1, 16'hFFE8, 16'h0012, 4'd4},  // R4 R5
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFE0, 16'h0012, 4'd2},  // R2 gie low
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hFFE2, 16'h0002, 4'd6},  // R6
        '{1'b1, 1'b0, 16'h0A02, 16'h0000, 1'b1, 1'b0, 1'b1, 16'hFFF6, 16'h0A02, 4'd3},  // R3
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hFFF2, 16'h0202, 4'd6},  // R6
        '{1'b1, 1'b0, 16'h0008, 16'h0000, 1'b1, 1'b0, 1'b1, 16'hFFE6, 16'h0008, 4'd3},  // R3
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hFFE6, 16'h0008, 4'd7},  // R7
        '{1'b1, 1'b0, 16'h0000, 16'h0008, 1'b1, 1'b0, 1'b1, 16'hFFE6, 16'h0008, 4'd8},  // R8
        '{1'b0, 1'b0, 16'h0000, 16'h4000, 1'b0, 1'b0, 1'b0, 16'hFFE0, 16'h4008, 4'd2},  // R2 not enabled
        '{1'b1, 1'b1, 16'hCFFF, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hFFFC, 16'hCFFF, 4'd10}, // R10
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'hFFFC, 16'h4008, 4'd7},  // R7 shared group
        '{1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFE0, 16'h0000, 4'd3},  // R3 clear
        '{1'b1, 1'b0, 16'h0020, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hFFE0, 16'h0020, 4'd2},  // R2
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 16'hFFE0, 16'h0020, 4'd9},  // R9
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 16'hFFEA, 16'h0020, 4'd5},  // R5
        '{1'b0, 1'b0, 16'h0000, 16'h0020, 1'b1, 1'b1, 1'b1, 16'hFFEA, 16'h0020, 4'd12}, // R12
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 16'hFFE0, 16'h0000, 4'd6}   // R6
    };

    task automatic check16(input string what, input int rq,
                           input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic sel, input logic [15:0] wd,
                        input logic [15:0] hw, input logic g, input logic acc);
        @(negedge clk);
        reg_we    = we;
        reg_sel   = sel;
        reg_wdata = wd;
        hw_event  = hw;
        gie       = g;
        accept    = acc;
        @(posedge clk);
        #1;
        reg_we   = 1'b0;
        hw_event = '0;
        accept   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen through the ports
        check16("req at reset", 1, {15'd0, irq_req}, 16'h0000);
        reg_sel = 1'b0; #1;
        check16("flags at reset", 1, reg_rdata, 16'h0000);
        reg_sel = 1'b1; #1;
        check16("enables at reset", 1, reg_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TABLE[i].we, TABLE[i].sel, TABLE[i].wdata, TABLE[i].hw,
                 TABLE[i].g, TABLE[i].acc);
            check16("irq_req", int'(TABLE[i].rq), {15'd0, irq_req}, {15'd0, TABLE[i].ereq});
            check16("irq_vector", int'(TABLE[i].rq), irq_vector, TABLE[i].evec);
            check16("reg_rdata", int'(TABLE[i].rq), reg_rdata, TABLE[i].erd);
        end

        // R4: entry 15 over entry 14, both non-maskable, gie low
        step(1'b1, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        step(1'b1, 1'b0, 16'hC000, 16'h0000, 1'b0, 1'b0);
        check16("idx top", 4, {12'd0, irq_idx}, 16'h000F);
        check16("vector top", 5, irq_vector, 16'hFFFE);

        // R1: reset in mid-run clears both words and the request
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check16("req after reset", 1, {15'd0, irq_req}, 16'h0000);
        reg_sel = 1'b0; #1;
        check16("flags after reset", 1, reg_rdata, 16'h0000);
        reg_sel = 1'b1; #1;
        check16("enables after reset", 1, reg_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule